// File: doc/BRIEF.md
# Compressed Instruction Decoder

This block turns one 16-bit compressed instruction word into a flat control bundle for the execution stage of a 64-bit core. The bundle holds an operation class, an operation code, a destination register index and two source register indices (each 5 bits, addressing a 32-entry register file), a 64-bit immediate that is already extended and scaled, a memory access size, a sign-extend-on-load flag, register and memory write enables, and an illegal-instruction flag.

Short register fields are widened into the full register file. Load and store offsets are scaled by the access width. A shift amount of zero is turned into eight. Compare results are sent to a fixed register. Branches and jumps are only classified and handed to a separate next-PC unit. Prefix words and the long jump formats are not expanded. The decoder holds no state and has no clock, so the bundle follows the instruction word within the same cycle.

Top module: `cdec_top`

## Requirements
- R1: A 3-bit register field (bits 10:8 = X, 7:5 = Y, 4:2 = Z) of value 0 selects register 16 and value 1 selects register 17. Values 2 to 7 select the register with the same number. SP is register 29 and RA is register 31.
- R2: Major opcodes (bits 15:11) 10000, 10100, 10001, 10101, 10011, 10111 and 00111 are loads (class 4, op 19). Their sizes are byte, byte, half, half, word, word and double. Only the first, third and fifth set the sign-extend flag. The destination is Y and the base is X. Register write is 1 and memory write is 0.
- R3: The immediate of a register-based load or store is bits 4:0, zero-extended and multiplied by 1, 2, 4 or 8 (size code 0, 1, 2, 3). Major 10010 is a signed word load into X, and major 11010 is a word store of X. Both use base 29 and the immediate bits 7:0 ×4.
- R4: Majors 11000, 11001, 11011 and 01111 are stores (class 5, op 19) of byte, half, word and double. The base is X and the data is Y. Memory write is 1 and register write is 0.
- R5: Major 11100 writes Z from sources X and Y. Bits 1:0 select the op: 01 add (1), 11 subtract (3), 00 64-bit add (2), 10 64-bit subtract (4).
- R6: Major 11101 uses function bits 4:0 for unary and logic ops. 01011 is negate: op 3, destination X, sources 0 and Y. 01111 is not: op 10, destination X, sources 0 and Y. 01100, 01101 and 01110 are and, or and xor (ops 7, 8, 9), each with destination X and sources X and Y.
- R7: Set-less-than (function 00010, op 5), unsigned set-less-than (00011, op 6) and compare (01010, op 9 xor) use sources X and Y. The immediate forms use majors 01010 (op 5), 01011 (op 6) and 01110 (op 9), with source X and bits 7:0 zero-extended. All six write register 24.
- R8: Major 00110 is an immediate shift (class 2). Bits 1:0 select the op: 00 left (11), 10 logical right (12), 11 arithmetic right (13), 01 64-bit left (14). The destination is X and the source is Y. The immediate is bits 4:2, with 0 read as 8.
- R9: Major 01101 loads a constant: op 8, destination X, source 0, bits 7:0 zero-extended. Major 01000 adds bits 3:0 sign-extended to X and writes Y; bit 4 selects op 1 or 2 (64-bit). Major 01001 adds bits 7:0 sign-extended to X and writes X.
- R10: Function codes 11000, 11001, 11010 and 11011 under major 11101 give class 3 with ops 15 to 18. Sources are X and Y. No register write and no memory write.
- R11: Control flow has class 6 with no write. The ops are: 00100 → op 20, source X. 00101 → op 21, source X. 01100 with bits 10:8 = 000 → op 22, or 001 → op 23, both with source 24. In these four the immediate is bits 7:0 sign-extended. 00010 → op 24, immediate bits 10:0 sign-extended. 00011 → op 25. Major 11101 with function 00000 → op 26, source X when bits 7:5 are 000 or 010, and 31 when they are 001.
- R12: Any other encoding sets the illegal flag and drives every other output to zero, including both write enables.
- R13: Class codes are 0 none, 1 ALU, 2 shift, 3 multiply/divide, 4 load, 5 store, 6 control. Op 0 means none. Outputs not named by a requirement are zero.
- R14: The outputs depend only on the present instruction word, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 16 | Compressed instruction word |
| cls_o | output | 3 | Operation class |
| op_o | output | 5 | Operation code |
| rd_o | output | 5 | Destination register index |
| ra_o | output | 5 | First source register index |
| rb_o | output | 5 | Second source register index |
| imm_o | output | 64 | Extended, scaled immediate |
| size_o | output | 2 | Memory access size (0 byte to 3 double) |
| lsign_o | output | 1 | Sign-extend loaded data |
| rd_we_o | output | 1 | Register write enable |
| mem_we_o | output | 1 | Memory write enable |
| illegal_o | output | 1 | Encoding not recognised |

## Verification
The two functions most likely to meet in one word are register-field widening and immediate shaping. A single load, store or shift can hold a 0 or 1 register field together with a maximal scaled offset or a zero shift count. Directed words set X and Y to 0 and 1 together with offset 31 or shift field 0. An exhaustive sweep of all 65536 words then meets every overlap. Every word is judged field by field against a behavioural model in the bench, which builds the expected bundle per mnemonic using arithmetic, not bit slicing.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

    localparam int unsigned INSN_W  = 16;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned XLEN    = 64;
    localparam int unsigned FIELD_W = 3;

    localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
    localparam logic [REG_W-1:0] REG_T8   = 5'd24;
    localparam logic [REG_W-1:0] REG_SP   = 5'd29;
    localparam logic [REG_W-1:0] REG_RA   = 5'd31;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_SHIFT  = 3'd2,
        CLS_MULDIV = 3'd3,
        CLS_LOAD   = 3'd4,
        CLS_STORE  = 3'd5,
        CLS_CTRL   = 3'd6
    } cls_e;

    typedef enum logic [4:0] {
        OP_NONE  = 5'd0,  OP_ADD   = 5'd1,  OP_DADD  = 5'd2,  OP_SUB   = 5'd3,
        OP_DSUB  = 5'd4,  OP_SLT   = 5'd5,  OP_SLTU  = 5'd6,  OP_AND   = 5'd7,
        OP_OR    = 5'd8,  OP_XOR   = 5'd9,  OP_NOR   = 5'd10, OP_SLL   = 5'd11,
        OP_SRL   = 5'd12, OP_SRA   = 5'd13, OP_DSLL  = 5'd14, OP_MUL   = 5'd15,
        OP_MULU  = 5'd16, OP_DIV   = 5'd17, OP_DIVU  = 5'd18, OP_MEM   = 5'd19,
        OP_BZ    = 5'd20, OP_BNZ   = 5'd21, OP_BTZ   = 5'd22, OP_BTNZ  = 5'd23,
        OP_BR    = 5'd24, OP_JLONG = 5'd25, OP_JREG  = 5'd26
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef struct packed {
        cls_e             cls;
        op_e              op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [XLEN-1:0]  imm;
        size_e            size;
        logic             lsign;
        logic             rd_we;
        logic             mem_we;
        logic             illegal;
    } dec_s;

    // Major opcodes, bits 15:11
    localparam logic [4:0] MJ_LDB   = 5'b10000;
    localparam logic [4:0] MJ_LDBU  = 5'b10100;
    localparam logic [4:0] MJ_LDH   = 5'b10001;
    localparam logic [4:0] MJ_LDHU  = 5'b10101;
    localparam logic [4:0] MJ_LDW   = 5'b10011;
    localparam logic [4:0] MJ_LDWU  = 5'b10111;
    localparam logic [4:0] MJ_LDD   = 5'b00111;
    localparam logic [4:0] MJ_LDWSP = 5'b10010;
    localparam logic [4:0] MJ_STB   = 5'b11000;
    localparam logic [4:0] MJ_STH   = 5'b11001;
    localparam logic [4:0] MJ_STW   = 5'b11011;
    localparam logic [4:0] MJ_STD   = 5'b01111;
    localparam logic [4:0] MJ_STWSP = 5'b11010;
    localparam logic [4:0] MJ_CONST = 5'b01101;
    localparam logic [4:0] MJ_ADDI4 = 5'b01000;
    localparam logic [4:0] MJ_ADDI8 = 5'b01001;
    localparam logic [4:0] MJ_SLTI  = 5'b01010;
    localparam logic [4:0] MJ_SLTIU = 5'b01011;
    localparam logic [4:0] MJ_CMPI  = 5'b01110;
    localparam logic [4:0] MJ_RRR   = 5'b11100;
    localparam logic [4:0] MJ_RR    = 5'b11101;
    localparam logic [4:0] MJ_SHIFT = 5'b00110;
    localparam logic [4:0] MJ_BR    = 5'b00010;
    localparam logic [4:0] MJ_JLONG = 5'b00011;
    localparam logic [4:0] MJ_BZ    = 5'b00100;
    localparam logic [4:0] MJ_BNZ   = 5'b00101;
    localparam logic [4:0] MJ_I8    = 5'b01100;

    function automatic logic [XLEN-1:0] sext4(input logic [3:0] v);
        return {{(XLEN-4){v[3]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext8(input logic [7:0] v);
        return {{(XLEN-8){v[7]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext11(input logic [10:0] v);
        return {{(XLEN-11){v[10]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext8(input logic [7:0] v);
        return {{(XLEN-8){1'b0}}, v};
    endfunction

    // Offset field scaled by the access width
    function automatic logic [XLEN-1:0] mem_offset(input logic [7:0] v, input size_e s);
        return zext8(v) << s;
    endfunction

    // A zero count field stands for eight
    function automatic logic [XLEN-1:0] shift_count(input logic [2:0] s);
        return (s == 3'd0) ? XLEN'(8) : XLEN'(s);
    endfunction

    function automatic size_e load_size(input logic [4:0] mj);
        case (mj)
            MJ_LDB, MJ_LDBU: return SZ_BYTE;
            MJ_LDH, MJ_LDHU: return SZ_HALF;
            MJ_LDW, MJ_LDWU: return SZ_WORD;
            default:         return SZ_DBL;
        endcase
    endfunction

    function automatic logic load_signed(input logic [4:0] mj);
        return (mj == MJ_LDB) || (mj == MJ_LDH) || (mj == MJ_LDW);
    endfunction

    function automatic size_e store_size(input logic [4:0] mj);
        case (mj)
            MJ_STB:  return SZ_BYTE;
            MJ_STH:  return SZ_HALF;
            MJ_STW:  return SZ_WORD;
            default: return SZ_DBL;
        endcase
    endfunction

endpackage

// File: rtl/cdec_regmap.sv
module cdec_regmap
    import cdec_pkg::*;
#(
    parameter int unsigned FW        = FIELD_W,
    parameter int unsigned RW        = REG_W,
    parameter int unsigned HIGH_BASE = 16
) (
    input  logic [FW-1:0] fld,
    output logic [RW-1:0] idx
);
    localparam int unsigned LOW_COUNT = 2;

    always_comb begin
        if (fld < FW'(LOW_COUNT)) idx = RW'(HIGH_BASE) + RW'(fld);
        else                      idx = RW'(fld);
    end

    always_comb begin
        if (!$isunknown(fld)) begin
            p_remap_window_r1: assert (idx >= RW'(LOW_COUNT) && idx < RW'(HIGH_BASE + LOW_COUNT))
                else $error("widened register index outside its window");
        end
    end
endmodule

// File: rtl/cdec_decode.sv
module cdec_decode
    import cdec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [REG_W-1:0]  rx,
    input  logic [REG_W-1:0]  ry,
    input  logic [REG_W-1:0]  rz,
    output dec_s              dec
);
    logic [4:0] major;
    logic [4:0] fn5;
    logic [1:0] sel2;
    logic [2:0] sub3;
    logic [2:0] mid3;
    logic       bad;
    dec_s       d;

    assign major = insn[15:11];
    assign fn5   = insn[4:0];
    assign sel2  = insn[1:0];
    assign sub3  = insn[10:8];
    assign mid3  = insn[7:5];

    always_comb begin
        d   = '0;
        bad = 1'b0;
        case (major)
            MJ_LDB, MJ_LDBU, MJ_LDH, MJ_LDHU, MJ_LDW, MJ_LDWU, MJ_LDD: begin
                d.cls   = CLS_LOAD;
                d.op    = OP_MEM;
                d.rd    = ry;
                d.ra    = rx;
                d.rd_we = 1'b1;
                d.size  = load_size(major);
                d.lsign = load_signed(major);
                d.imm   = mem_offset({3'b000, insn[4:0]}, d.size);
            end
            MJ_LDWSP: begin
                d.cls   = CLS_LOAD;
                d.op    = OP_MEM;
                d.rd    = rx;
                d.ra    = REG_SP;
                d.rd_we = 1'b1;
                d.size  = SZ_WORD;
                d.lsign = 1'b1;
                d.imm   = mem_offset(insn[7:0], SZ_WORD);
            end
            MJ_STB, MJ_STH, MJ_STW, MJ_STD: begin
                d.cls    = CLS_STORE;
                d.op     = OP_MEM;
                d.ra     = rx;
                d.rb     = ry;
                d.mem_we = 1'b1;
                d.size   = store_size(major);
                d.imm    = mem_offset({3'b000, insn[4:0]}, d.size);
            end
            MJ_STWSP: begin
                d.cls    = CLS_STORE;
                d.op     = OP_MEM;
                d.ra     = REG_SP;
                d.rb     = rx;
                d.mem_we = 1'b1;
                d.size   = SZ_WORD;
                d.imm    = mem_offset(insn[7:0], SZ_WORD);
            end
            MJ_CONST: begin
                d.cls   = CLS_ALU;
                d.op    = OP_OR;
                d.rd    = rx;
                d.ra    = REG_ZERO;
                d.rd_we = 1'b1;
                d.imm   = zext8(insn[7:0]);
            end
            MJ_ADDI4: begin
                d.cls   = CLS_ALU;
                d.op    = insn[4] ? OP_DADD : OP_ADD;
                d.rd    = ry;
                d.ra    = rx;
                d.rd_we = 1'b1;
                d.imm   = sext4(insn[3:0]);
            end
            MJ_ADDI8: begin
                d.cls   = CLS_ALU;
                d.op    = OP_ADD;
                d.rd    = rx;
                d.ra    = rx;
                d.rd_we = 1'b1;
                d.imm   = sext8(insn[7:0]);
            end
            MJ_SLTI, MJ_SLTIU, MJ_CMPI: begin
                d.cls   = CLS_ALU;
                d.op    = (major == MJ_SLTI)  ? OP_SLT :
                          (major == MJ_SLTIU) ? OP_SLTU : OP_XOR;
                d.rd    = REG_T8;
                d.ra    = rx;
                d.rd_we = 1'b1;
                d.imm   = zext8(insn[7:0]);
            end
            MJ_RRR: begin
                d.cls   = CLS_ALU;
                d.rd    = rz;
                d.ra    = rx;
                d.rb    = ry;
                d.rd_we = 1'b1;
                case (sel2)
                    2'b01:   d.op = OP_ADD;
                    2'b11:   d.op = OP_SUB;
                    2'b00:   d.op = OP_DADD;
                    default: d.op = OP_DSUB;
                endcase
            end
            MJ_RR: begin
                d.cls   = CLS_ALU;
                d.ra    = rx;
                d.rb    = ry;
                d.rd    = rx;
                d.rd_we = 1'b1;
                case (fn5)
                    5'b00010: begin d.op = OP_SLT;  d.rd = REG_T8; end
                    5'b00011: begin d.op = OP_SLTU; d.rd = REG_T8; end
                    5'b01010: begin d.op = OP_XOR;  d.rd = REG_T8; end
                    5'b01011: begin d.op = OP_SUB;  d.ra = REG_ZERO; end
                    5'b01111: begin d.op = OP_NOR;  d.ra = REG_ZERO; end
                    5'b01100: d.op = OP_AND;
                    5'b01101: d.op = OP_OR;
                    5'b01110: d.op = OP_XOR;
                    5'b11000, 5'b11001, 5'b11010, 5'b11011: begin
                        d.cls   = CLS_MULDIV;
                        d.rd    = REG_ZERO;
                        d.rd_we = 1'b0;
                        case (fn5[1:0])
                            2'b00:   d.op = OP_MUL;
                            2'b01:   d.op = OP_MULU;
                            2'b10:   d.op = OP_DIV;
                            default: d.op = OP_DIVU;
                        endcase
                    end
                    5'b00000: begin
                        d.cls   = CLS_CTRL;
                        d.op    = OP_JREG;
                        d.rd    = REG_ZERO;
                        d.rb    = REG_ZERO;
                        d.rd_we = 1'b0;
                        case (mid3)
                            3'b000, 3'b010: d.ra = rx;
                            3'b001:         d.ra = REG_RA;
                            default:        bad  = 1'b1;
                        endcase
                    end
                    default: bad = 1'b1;
                endcase
            end
            MJ_SHIFT: begin
                d.cls   = CLS_SHIFT;
                d.rd    = rx;
                d.ra    = ry;
                d.rd_we = 1'b1;
                d.imm   = shift_count(insn[4:2]);
                case (sel2)
                    2'b00:   d.op = OP_SLL;
                    2'b10:   d.op = OP_SRL;
                    2'b11:   d.op = OP_SRA;
                    default: d.op = OP_DSLL;
                endcase
            end
            MJ_BR: begin
                d.cls = CLS_CTRL;
                d.op  = OP_BR;
                d.imm = sext11(insn[10:0]);
            end
            MJ_JLONG: begin
                d.cls = CLS_CTRL;
                d.op  = OP_JLONG;
            end
            MJ_BZ, MJ_BNZ: begin
                d.cls = CLS_CTRL;
                d.op  = (major == MJ_BZ) ? OP_BZ : OP_BNZ;
                d.ra  = rx;
                d.imm = sext8(insn[7:0]);
            end
            MJ_I8: begin
                d.cls = CLS_CTRL;
                d.ra  = REG_T8;
                d.imm = sext8(insn[7:0]);
                case (sub3)
                    3'b000:  d.op = OP_BTZ;
                    3'b001:  d.op = OP_BTNZ;
                    default: bad  = 1'b1;
                endcase
            end
            default: bad = 1'b1;
        endcase

        if (bad) begin
            dec         = '0;
            dec.illegal = 1'b1;
        end else begin
            dec = d;
        end
    end

    always_comb begin
        if (!$isunknown(insn)) begin
            p_shift_span_r8: assert (dec.cls != CLS_SHIFT || (dec.imm >= XLEN'(1) && dec.imm <= XLEN'(8)))
                else $error("shift count outside 1..8");
            p_cmp_to_t8_r7: assert (!(dec.cls == CLS_ALU && (dec.op == OP_SLT || dec.op == OP_SLTU)) || dec.rd == REG_T8)
                else $error("set-less-than result not steered to register 24");
            p_muldiv_nowrite_r10: assert (dec.cls != CLS_MULDIV || (!dec.rd_we && !dec.mem_we))
                else $error("multiply/divide requests a write");
        end
    end
endmodule

// File: rtl/cdec_top.sv
module cdec_top
    import cdec_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output logic [2:0]        cls_o,
    output logic [4:0]        op_o,
    output logic [REG_W-1:0]  rd_o,
    output logic [REG_W-1:0]  ra_o,
    output logic [REG_W-1:0]  rb_o,
    output logic [XLEN-1:0]   imm_o,
    output logic [1:0]        size_o,
    output logic              lsign_o,
    output logic              rd_we_o,
    output logic              mem_we_o,
    output logic              illegal_o
);
    localparam int unsigned NUM_FIELDS = 3;
    localparam int unsigned TOP_LSB    = 8;

    logic [REG_W-1:0] widened [NUM_FIELDS];
    dec_s             dec;

    // Fields X (10:8), Y (7:5) and Z (4:2), each widened the same way
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int unsigned LSB = TOP_LSB - FIELD_W * g;
        cdec_regmap #(
            .FW        (FIELD_W),
            .RW        (REG_W),
            .HIGH_BASE (16)
        ) u_map (
            .fld (insn_i[LSB +: FIELD_W]),
            .idx (widened[g])
        );
    end

    cdec_decode u_dec (
        .insn (insn_i),
        .rx   (widened[0]),
        .ry   (widened[1]),
        .rz   (widened[2]),
        .dec  (dec)
    );

    assign cls_o     = dec.cls;
    assign op_o      = dec.op;
    assign rd_o      = dec.rd;
    assign ra_o      = dec.ra;
    assign rb_o      = dec.rb;
    assign imm_o     = dec.imm;
    assign size_o    = dec.size;
    assign lsign_o   = dec.lsign;
    assign rd_we_o   = dec.rd_we;
    assign mem_we_o  = dec.mem_we;
    assign illegal_o = dec.illegal;

    always_comb begin
        if (!$isunknown(insn_i)) begin
            p_illegal_quiet_r12: assert (!illegal_o || (!rd_we_o && !mem_we_o && cls_o == 3'd0))
                else $error("illegal word still enables a write");
            p_dest_widened_r1: assert (!rd_we_o || rd_o >= REG_W'(2))
                else $error("register write aimed at register 0 or 1");
            p_store_shape_r4: assert (!mem_we_o || (!rd_we_o && cls_o == 3'd5))
                else $error("memory write outside store class");
            p_offset_aligned_r3: assert (!(cls_o == 3'd4 || cls_o == 3'd5) ||
                                         ((imm_o & ((XLEN'(1) << size_o) - XLEN'(1))) == '0))
                else $error("memory offset not aligned to access size");
        end
    end
endmodule

// File: tb/tb_cdec_top.sv
`timescale 1ns/1ps
module tb_cdec_top;

    typedef struct packed {
        logic [2:0]  cls;
        logic [4:0]  op;
        logic [4:0]  rd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [63:0] imm;
        logic [1:0]  sz;
        logic        ls;
        logic        rwe;
        logic        mwe;
        logic        ill;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_en = 1'b0;
    logic [15:0] insn = 16'h0000;
    int          checks = 0;
    int          errors = 0;

    logic [2:0]  cls_o;
    logic [4:0]  op_o, rd_o, ra_o, rb_o;
    logic [63:0] imm_o;
    logic [1:0]  size_o;
    logic        lsign_o, rd_we_o, mem_we_o, illegal_o;

    always #2 clk = ~clk;

    cdec_top dut (
        .insn_i    (insn),
        .cls_o     (cls_o),
        .op_o      (op_o),
        .rd_o      (rd_o),
        .ra_o      (ra_o),
        .rb_o      (rb_o),
        .imm_o     (imm_o),
        .size_o    (size_o),
        .lsign_o   (lsign_o),
        .rd_we_o   (rd_we_o),
        .mem_we_o  (mem_we_o),
        .illegal_o (illegal_o)
    );

    function automatic logic [4:0] wid(input logic [2:0] f);
        int n;
        n = f;
        if (n < 2) n = n + 16;
        return 5'(n);
    endfunction

    function automatic string show(input exp_t v);
        return $sformatf("cls=%0d op=%0d rd=%0d ra=%0d rb=%0d imm=%h sz=%0d ls=%0b rwe=%0b mwe=%0b ill=%0b",
                         v.cls, v.op, v.rd, v.ra, v.rb, v.imm, v.sz, v.ls, v.rwe, v.mwe, v.ill);
    endfunction

    // Behavioural reference: expected bundle per mnemonic
    function automatic exp_t model(input logic [15:0] w, output string tag);
        exp_t   e;
        logic [4:0] x, y, z;
        longint v;
        int     scale;
        e = '0;
        x = wid(w[10:8]);
        y = wid(w[7:5]);
        z = wid(w[4:2]);
        tag = "R12";
        casez (w)
            16'b10000_???????????, 16'b10100_???????????, 16'b10001_???????????,
            16'b10101_???????????, 16'b10011_???????????, 16'b10111_???????????,
            16'b00111_???????????: begin
                tag = "R2/R3";
                if (w[15:11] == 5'b00111) e.sz = 2'd3;
                else if (w[12:11] == 2'b00) e.sz = 2'd0;
                else if (w[12:11] == 2'b01) e.sz = 2'd1;
                else e.sz = 2'd2;
                e.ls  = (w[15:11] == 5'b10000 || w[15:11] == 5'b10001 || w[15:11] == 5'b10011);
                scale = 1 << e.sz;
                e.cls = 4; e.op = 19; e.rd = y; e.ra = x; e.rwe = 1;
                e.imm = 64'(w[4:0] * scale);
            end
            16'b11000_???????????, 16'b11001_???????????, 16'b11011_???????????,
            16'b01111_???????????: begin
                tag = "R4/R3";
                case (w[15:11])
                    5'b11000: e.sz = 2'd0;
                    5'b11001: e.sz = 2'd1;
                    5'b11011: e.sz = 2'd2;
                    default:  e.sz = 2'd3;
                endcase
                scale = 1 << e.sz;
                e.cls = 5; e.op = 19; e.ra = x; e.rb = y; e.mwe = 1;
                e.imm = 64'(w[4:0] * scale);
            end
            16'b10010_???????????: begin
                tag = "R3";
                e.cls = 4; e.op = 19; e.rd = x; e.ra = 29; e.rwe = 1; e.sz = 2; e.ls = 1;
                e.imm = 64'(w[7:0] * 4);
            end
            16'b11010_???????????: begin
                tag = "R3";
                e.cls = 5; e.op = 19; e.ra = 29; e.rb = x; e.mwe = 1; e.sz = 2;
                e.imm = 64'(w[7:0] * 4);
            end
            16'b01101_???????????: begin
                tag = "R9";
                e.cls = 1; e.op = 8; e.rd = x; e.rwe = 1; e.imm = 64'(w[7:0]);
            end
            16'b01000_???????????: begin
                tag = "R9";
                v = w[3:0];
                if (w[3]) v = v - 16;
                e.cls = 1; e.op = w[4] ? 2 : 1; e.rd = y; e.ra = x; e.rwe = 1; e.imm = 64'(v);
            end
            16'b01001_???????????: begin
                tag = "R9";
                v = w[7:0];
                if (w[7]) v = v - 256;
                e.cls = 1; e.op = 1; e.rd = x; e.ra = x; e.rwe = 1; e.imm = 64'(v);
            end
            16'b01010_???????????, 16'b01011_???????????, 16'b01110_???????????: begin
                tag = "R7";
                e.cls = 1; e.rd = 24; e.ra = x; e.rwe = 1; e.imm = 64'(w[7:0]);
                e.op = (w[15:11] == 5'b01010) ? 5 : (w[15:11] == 5'b01011) ? 6 : 9;
            end
            16'b11100_???????????: begin
                tag = "R5";
                e.cls = 1; e.rd = z; e.ra = x; e.rb = y; e.rwe = 1;
                case (w[1:0])
                    2'b01: e.op = 1;
                    2'b11: e.op = 3;
                    2'b00: e.op = 2;
                    default: e.op = 4;
                endcase
            end
            16'b00110_???????????: begin
                tag = "R8";
                e.cls = 2; e.rd = x; e.ra = y; e.rwe = 1;
                e.imm = (w[4:2] == 0) ? 64'd8 : 64'(w[4:2]);
                case (w[1:0])
                    2'b00: e.op = 11;
                    2'b10: e.op = 12;
                    2'b11: e.op = 13;
                    default: e.op = 14;
                endcase
            end
            16'b00010_???????????: begin
                tag = "R11";
                v = w[10:0];
                if (w[10]) v = v - 2048;
                e.cls = 6; e.op = 24; e.imm = 64'(v);
            end
            16'b00011_???????????: begin
                tag = "R11"; e.cls = 6; e.op = 25;
            end
            16'b00100_???????????, 16'b00101_???????????: begin
                tag = "R11";
                v = w[7:0];
                if (w[7]) v = v - 256;
                e.cls = 6; e.op = w[11] ? 21 : 20; e.ra = x; e.imm = 64'(v);
            end
            16'b01100_???????????: begin
                if (w[10:9] == 2'b00) begin
                    tag = "R11";
                    v = w[7:0];
                    if (w[7]) v = v - 256;
                    e.cls = 6; e.op = w[8] ? 23 : 22; e.ra = 24; e.imm = 64'(v);
                end
            end
            16'b11101_???????????: begin
                e.cls = 1; e.ra = x; e.rb = y; e.rd = x; e.rwe = 1;
                case (w[4:0])
                    5'b00010: begin tag = "R7"; e.op = 5; e.rd = 24; end
                    5'b00011: begin tag = "R7"; e.op = 6; e.rd = 24; end
                    5'b01010: begin tag = "R7"; e.op = 9; e.rd = 24; end
                    5'b01011: begin tag = "R6"; e.op = 3; e.ra = 0; end
                    5'b01111: begin tag = "R6"; e.op = 10; e.ra = 0; end
                    5'b01100: begin tag = "R6"; e.op = 7; end
                    5'b01101: begin tag = "R6"; e.op = 8; end
                    5'b01110: begin tag = "R6"; e.op = 9; end
                    5'b11000, 5'b11001, 5'b11010, 5'b11011: begin
                        tag = "R10"; e.cls = 3; e.rd = 0; e.rwe = 0;
                        e.op = 5'(15 + int'(w[1:0]));
                    end
                    5'b00000: begin
                        tag = "R11"; e.cls = 6; e.op = 26; e.rd = 0; e.rb = 0; e.rwe = 0;
                        if (w[7:5] == 3'b001) e.ra = 31;
                        else if (w[7:5] != 3'b000 && w[7:5] != 3'b010) e = '0;
                    end
                    default: e = '0;
                endcase
                if (e.cls == 0) tag = "R12";
            end
            default: ;
        endcase
        if (e.cls == 0) begin
            e = '0;
            e.ill = 1'b1;
            tag = "R12";
        end
        return e;
    endfunction

    function automatic exp_t actual();
        exp_t a;
        a = {cls_o, op_o, rd_o, ra_o, rb_o, imm_o, size_o, lsign_o, rd_we_o, mem_we_o, illegal_o};
        return a;
    endfunction

    // Per-cycle comparison against the reference, away from the driving edge
    always @(negedge clk) begin
        exp_t  e;
        exp_t  a;
        string tag;
        if (!rst && chk_en) begin
            e = model(insn, tag);
            a = actual();
            checks++;
            if (a !== e) begin
                errors++;
                if (a.cls !== e.cls || a.op !== e.op) tag = {tag, "/R13"};
                $display("FAIL %s insn=%h actual: %s expected: %s", tag, insn, show(a), show(e));
            end
        end
    end

    task automatic apply(input logic [15:0] w);
        @(posedge clk);
        insn <= w;
    endtask

    task automatic direct(input string req, input logic cond, input string got, input string want);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual: %s expected: %s", req, got, want);
        end
    endtask

    localparam int NDIR = 48;
    localparam logic [15:0] DIR [NDIR] = '{
        {5'b10000, 3'd0, 3'd1, 5'd31},          // R1 fields 0/1, R2 signed byte
        {5'b10011, 3'd7, 3'd2, 5'd31},          // R1 passthrough, R3 word x4
        {5'b10100, 3'd3, 3'd4, 5'd5},           // R2 unsigned byte
        {5'b10001, 3'd1, 3'd0, 5'd31},          // R2 signed half
        {5'b10101, 3'd5, 3'd6, 5'd1},           // R2 unsigned half
        {5'b10111, 3'd2, 3'd3, 5'd7},           // R2 unsigned word
        {5'b00111, 3'd0, 3'd0, 5'd31},          // R3 double x8
        {5'b10010, 3'd1, 8'hFF},                // R3 sp load
        {5'b11010, 3'd0, 8'h80},                // R3 sp store
        {5'b11000, 3'd0, 3'd1, 5'd3},           // R4 byte store
        {5'b11001, 3'd6, 3'd7, 5'd31},          // R4 half store
        {5'b11011, 3'd1, 3'd1, 5'd16},          // R4 word store
        {5'b01111, 3'd2, 3'd0, 5'd31},          // R4 double store
        {5'b11100, 3'd0, 3'd1, 3'd0, 2'b01},    // R5 add, z=0
        {5'b11100, 3'd2, 3'd3, 3'd1, 2'b11},    // R5 sub
        {5'b11100, 3'd4, 3'd5, 3'd6, 2'b00},    // R5 dadd
        {5'b11100, 3'd7, 3'd0, 3'd2, 2'b10},    // R5 dsub
        {5'b11101, 3'd0, 3'd2, 5'b01011},       // R6 negate
        {5'b11101, 3'd3, 3'd1, 5'b01111},       // R6 not
        {5'b11101, 3'd4, 3'd5, 5'b01100},       // R6 and
        {5'b11101, 3'd1, 3'd6, 5'b01101},       // R6 or
        {5'b11101, 3'd7, 3'd0, 5'b01110},       // R6 xor
        {5'b11101, 3'd2, 3'd3, 5'b00010},       // R7 slt
        {5'b11101, 3'd0, 3'd1, 5'b00011},       // R7 sltu
        {5'b11101, 3'd5, 3'd4, 5'b01010},       // R7 cmp
        {5'b01010, 3'd1, 8'hF0},                // R7 slti, zero-extended
        {5'b01011, 3'd3, 8'h7F},                // R7 sltiu
        {5'b01110, 3'd0, 8'hAA},                // R7 cmpi
        {5'b00110, 3'd0, 3'd1, 3'd0, 2'b00},    // R8 count 0 means 8
        {5'b00110, 3'd2, 3'd3, 3'd7, 2'b11},    // R8 arithmetic right 7
        {5'b00110, 3'd4, 3'd5, 3'd1, 2'b10},    // R8 logical right 1
        {5'b00110, 3'd6, 3'd7, 3'd0, 2'b01},    // R8 64-bit left, count 8
        {5'b01101, 3'd1, 8'hFF},                // R9 constant
        {5'b01000, 3'd2, 3'd0, 1'b0, 4'hF},     // R9 add -1
        {5'b01000, 3'd0, 3'd4, 1'b1, 4'h7},     // R9 64-bit add +7
        {5'b01001, 3'd5, 8'h80},                // R9 add -128
        {5'b11101, 3'd1, 3'd2, 5'b11000},       // R10 mult
        {5'b11101, 3'd3, 3'd4, 5'b11011},       // R10 divu
        {5'b00010, 11'h400},                    // R11 branch, negative
        {5'b00011, 11'h123},                    // R11 long jump
        {5'b00100, 3'd0, 8'h81},                // R11 branch if zero
        {5'b00101, 3'd6, 8'h01},                // R11 branch if nonzero
        {5'b01100, 3'b001, 8'hFE},              // R11 branch on t8
        {5'b11101, 3'd0, 3'b001, 5'b00000},     // R11 return via RA
        {5'b11101, 3'd1, 3'b010, 5'b00000},     // R11 jump with link
        {5'b01100, 3'b010, 8'h10},              // R12 unused sub-op
        {5'b11101, 3'd2, 3'b011, 5'b00000},     // R12 unused jump form
        {5'b11101, 3'd2, 3'd3, 5'b00001}        // R12 unused function
    };

    initial begin
        exp_t a;
        insn = 16'h0000;
        rst  = 1'b1;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        a = actual();
        // R12: the word present out of reset (all zero) is not a recognised encoding
        direct("R12 reset", a.ill === 1'b1 && a.rwe === 1'b0 && a.mwe === 1'b0 && a.cls === 3'd0,
               show(a), "ill=1 rwe=0 mwe=0 cls=0");
        chk_en = 1'b1;
        for (int i = 0; i < NDIR; i++) apply(DIR[i]);
        for (int i = 0; i < 65536; i++) apply(16'(i));
        @(posedge clk);
        @(negedge clk);
        chk_en = 1'b0;
        // R14: bundle follows the word with no clock edge in between
        insn = {5'b01101, 3'd2, 8'h05};
        #0.5;
        a = actual();
        direct("R14", a.ill === 1'b0 && a.rwe === 1'b1 && a.rd === 5'd2 && a.imm === 64'd5,
               show(a), "ill=0 rwe=1 rd=2 imm=5");
        insn = 16'h0000;
        #0.5;
        a = actual();
        direct("R14", a.ill === 1'b1 && a.rwe === 1'b0, show(a), "ill=1 rwe=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #760000;
        errors++;
        checks++;
        $display("FAIL watchdog R14 actual: run still active expected: run complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule